// File: doc/BRIEF.md
# Multi-mode programmable interval counter

One down-counting timer channel with a gate input and a single output. A host selects one of six operating modes with a mode word and then loads a 16-bit count as two byte writes, low byte first. Depending on the mode the channel produces a level that rises at terminal count, a retriggerable one-shot, a periodic one-clock low pulse, a square wave, or a one-clock strobe started by software or by a gate edge. The current count can be read back as two bytes at any time without disturbing the counting.

The counter is clocked by `clk` and decrements once per rising edge while it is enabled. The gate input is asynchronous. It passes through a synchroniser, and its rising edges are detected on `clk`. The control core is a five-state machine. IDLE means a mode is set and no count has been loaded. ARMED means a count is held and the channel waits for a gate trigger. RUN means the channel is counting. PULSE is the one-clock strobe. DONE means the count has expired and the channel waits for software.

The transitions are as follows. A mode write moves any state to IDLE. A count load moves IDLE to RUN in modes 0, 2, 3 and 4, and IDLE to ARMED in modes 1 and 5. A gate trigger moves ARMED, RUN, PULSE or DONE to RUN in modes 1 and 5. Terminal count moves RUN to DONE in mode 0, RUN to ARMED in mode 1, and RUN to PULSE in modes 4 and 5. In modes 2 and 3, terminal count reloads the count and the channel stays in RUN. PULSE moves to DONE in mode 4 and to ARMED in mode 5.

Top module: `interval_timer_channel`

## Requirements
- R1: After reset the channel is in mode 0 and IDLE, with `tmr_out` low and `rd_data` zero. A write with `wr_addr`=0 is a mode word: bits [2:0] select the mode, and codes 6 and 7 act as modes 2 and 3. A mode write returns the channel to IDLE with its output at the mode's idle level (low for mode 0, high otherwise) and resets both byte pointers to the low byte. Writes with `wr_addr`=1 alternate low byte then high byte, and the count takes effect on the high byte.
- R2: Mode 0: a count load drives the output low at the next edge. The output stays low for N enabled clocks, then stays high until the next count or mode write. A low gate pauses the count.
- R3: Mode 1: once a count is held, the first clock edge that sees a synchronised gate rising edge drives the output low for N clocks. A rising edge during the pulse restarts the full count.
- R4: Modes 1 and 5: a count written while counting leaves the running period unchanged and is used from the next trigger.
- R5: Mode 2: the output stays high after the mode write until a count is loaded. It is then low for exactly one clock in every N clocks (N >= 2).
- R6: Mode 2: a count written while running applies from the next period. A low gate forces the output high and holds the count, and a gate rising edge restarts from the loaded count.
- R7: Mode 3 (N >= 2): the output is high for ceil(N/2) clocks and low for floor(N/2) clocks. A low gate forces the output high and holds the count.
- R8: Mode 4: the output is high after the mode write. A count load starts counting. After N enabled clocks the output is low for exactly one clock and then high. A low gate inhibits counting, and a new count load restarts with the new value.
- R9: Mode 5: a gate trigger starts counting from the held count. The output stays high for N clocks, goes low for exactly one clock, and the channel re-arms.
- R10: A read strobe returns the count's low byte on `rd_data` at the next edge, and the following strobe returns the high byte. Reads change neither the count nor the output.
- R11: The gate is synchronised by SYNC_STAGES flops. With the default of 2, a gate rise set up before edge k is acted on at edge k+2.
- R12: When a high count byte and a gate trigger fall on the same edge in modes 1 or 5, the trigger uses the newly written count.
- R13: A loaded count of zero counts 65536 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_addr | input | 1 | 0 selects the mode word, 1 selects a count byte |
| wr_data | input | BYTE_W | Write data |
| rd_en | input | 1 | Read strobe for count bytes |
| rd_data | output | BYTE_W | Registered count byte, low then high |
| gate_in | input | 1 | Asynchronous gate |
| tmr_out | output | 1 | Channel output |

## Verification
A count write and a gate trigger can land on the same clock edge in the edge-triggered modes. This is also where the reload rule and the trigger rule meet. The bench raises the gate two edges before the high count byte is written, so that the synchronised rising edge and the load coincide. It then judges the result by the length of the low pulse, which must equal the new count rather than the old one. The per-cycle reference model also checks the same kind of overlap between reloads and terminal counts in the periodic modes.

// File: rtl/itc_pkg.sv
package itc_pkg;

    typedef enum logic [2:0] {
        MD_TC_IRQ    = 3'd0,
        MD_ONESHOT   = 3'd1,
        MD_RATE      = 3'd2,
        MD_SQUARE    = 3'd3,
        MD_SW_STROBE = 3'd4,
        MD_HW_STROBE = 3'd5
    } itc_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_RUN   = 3'd2,
        ST_PULSE = 3'd3,
        ST_DONE  = 3'd4
    } itc_state_e;

endpackage

// File: rtl/itc_gate_sync.sv
module itc_gate_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_in,
    output logic gate_lvl,
    output logic gate_rise
);
    // STAGES must be at least 2
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], gate_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign gate_lvl  = sync_q[STAGES-1];
    assign gate_rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/itc_host_port.sv
module itc_host_port
    import itc_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [CNT_W-1:0]  cur_cnt,
    output logic              mode_wr,
    output itc_mode_e         mode_code,
    output logic              load_pulse,
    output logic [CNT_W:0]    load_val,
    output logic [BYTE_W-1:0] rd_data
);
    logic [BYTE_W-1:0] lo_hold;
    logic              wr_hi;
    logic              rd_hi;
    logic              cnt_wr;
    logic [CNT_W-1:0]  raw_cnt;

    assign mode_wr    = wr_en & ~wr_addr;
    assign cnt_wr     = wr_en &  wr_addr;
    assign load_pulse = cnt_wr & wr_hi;
    assign raw_cnt    = {wr_data, lo_hold};
    // zero stands for the full range
    assign load_val   = (raw_cnt == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, raw_cnt};

    always_comb begin
        if (wr_data[2:1] == 2'b11) mode_code = itc_mode_e'({1'b0, wr_data[1:0]});
        else                       mode_code = itc_mode_e'(wr_data[2:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_hold <= '0;
            wr_hi   <= 1'b0;
            rd_hi   <= 1'b0;
            rd_data <= '0;
        end else begin
            if (mode_wr) begin
                wr_hi <= 1'b0;
            end else if (cnt_wr) begin
                if (!wr_hi) lo_hold <= wr_data;
                wr_hi <= ~wr_hi;
            end
            if (mode_wr)    rd_hi <= 1'b0;
            else if (rd_en) rd_hi <= ~rd_hi;
            if (rd_en) rd_data <= rd_hi ? cur_cnt[CNT_W-1:BYTE_W] : cur_cnt[BYTE_W-1:0];
        end
    end
endmodule

// File: rtl/itc_count_core.sv
module itc_count_core
    import itc_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    localparam int unsigned VAL_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  itc_mode_e        mode_code,
    input  logic             load_pulse,
    input  logic [VAL_W-1:0] load_val,
    input  logic             gate_lvl,
    input  logic             gate_rise,
    output logic             tmr_out,
    output itc_mode_e        cur_mode,
    output logic [CNT_W-1:0] cur_cnt
);
    localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

    itc_state_e       state_q, state_d;
    itc_mode_e        mode_q;
    logic [VAL_W-1:0] cnt_q, cnt_d;
    logic [VAL_W-1:0] init_q;
    logic [VAL_W-1:0] period_q, period_d;
    logic [VAL_W-1:0] init_nx;
    logic             restart_on_load, edge_mode, periodic, count_en;

    assign restart_on_load = (mode_q == MD_TC_IRQ)  || (mode_q == MD_SW_STROBE);
    assign edge_mode       = (mode_q == MD_ONESHOT) || (mode_q == MD_HW_STROBE);
    assign periodic        = (mode_q == MD_RATE)    || (mode_q == MD_SQUARE);
    assign count_en        = edge_mode | gate_lvl;
    assign init_nx         = load_pulse ? load_val : init_q;

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        period_d = period_q;
        if (mode_wr) begin
            state_d  = ST_IDLE;
            cnt_d    = '0;
            period_d = '0;
        end else if (load_pulse && restart_on_load) begin
            state_d = ST_RUN;
            cnt_d   = load_val;
        end else if (edge_mode && gate_rise && (state_q != ST_IDLE || load_pulse)) begin
            state_d = ST_RUN;
            cnt_d   = init_nx;
        end else if (edge_mode && load_pulse && state_q == ST_IDLE) begin
            state_d = ST_ARMED;
        end else if (periodic && load_pulse && state_q == ST_IDLE) begin
            state_d  = ST_RUN;
            cnt_d    = load_val;
            period_d = load_val;
        end else if (periodic && gate_rise && state_q == ST_RUN) begin
            cnt_d    = init_nx;
            period_d = init_nx;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (count_en) begin
                        if (cnt_q == ONE) begin
                            unique case (mode_q)
                                MD_TC_IRQ:    state_d = ST_DONE;
                                MD_ONESHOT:   state_d = ST_ARMED;
                                MD_RATE,
                                MD_SQUARE: begin
                                    cnt_d    = init_nx;
                                    period_d = init_nx;
                                end
                                MD_SW_STROBE,
                                MD_HW_STROBE: begin
                                    state_d = ST_PULSE;
                                    cnt_d   = '0;
                                end
                                default: ;
                            endcase
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                end
                ST_PULSE: state_d = (mode_q == MD_SW_STROBE) ? ST_DONE : ST_ARMED;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mode_q   <= MD_TC_IRQ;
            cnt_q    <= '0;
            init_q   <= '0;
            period_q <= '0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            period_q <= period_d;
            if (mode_wr)    mode_q <= mode_code;
            if (load_pulse) init_q <= load_val;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:  tmr_out = (mode_q != MD_TC_IRQ);
            ST_ARMED: tmr_out = 1'b1;
            ST_PULSE: tmr_out = 1'b0;
            ST_DONE:  tmr_out = 1'b1;
            ST_RUN: begin
                unique case (mode_q)
                    MD_TC_IRQ,
                    MD_ONESHOT: tmr_out = 1'b0;
                    MD_RATE:    tmr_out = !(cnt_q == ONE && gate_lvl);
                    MD_SQUARE:  tmr_out = !gate_lvl || (cnt_q > (period_q >> 1));
                    default:    tmr_out = 1'b1;
                endcase
            end
            default:  tmr_out = 1'b1;
        endcase
    end

    assign cur_mode = mode_q;
    assign cur_cnt  = cnt_q[CNT_W-1:0];
endmodule

// File: rtl/interval_timer_channel.sv
module interval_timer_channel
    import itc_pkg::*;
#(
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              gate_in,
    output logic              tmr_out
);
    localparam int unsigned CNT_W = 2 * BYTE_W;

    logic             host_mode_wr;
    itc_mode_e        host_mode_code;
    logic             host_load;
    logic [CNT_W:0]   host_load_val;
    logic             sync_lvl;
    logic             sync_rise;
    itc_mode_e        core_mode;
    logic [CNT_W-1:0] core_cnt;

    itc_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_in  (gate_in),
        .gate_lvl (sync_lvl),
        .gate_rise(sync_rise)
    );

    itc_host_port #(.BYTE_W(BYTE_W)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .cur_cnt   (core_cnt),
        .mode_wr   (host_mode_wr),
        .mode_code (host_mode_code),
        .load_pulse(host_load),
        .load_val  (host_load_val),
        .rd_data   (rd_data)
    );

    itc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr   (host_mode_wr),
        .mode_code (host_mode_code),
        .load_pulse(host_load),
        .load_val  (host_load_val),
        .gate_lvl  (sync_lvl),
        .gate_rise (sync_rise),
        .tmr_out   (tmr_out),
        .cur_mode  (core_mode),
        .cur_cnt   (core_cnt)
    );
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_wr,
    input logic       load_pulse,
    input logic       gate_lvl,
    input logic [2:0] cur_mode,
    input logic       tmr_out
);
    // R1
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (tmr_out == (cur_mode != 3'd0)));

    // R2
    tc_load_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd0 && load_pulse && !mode_wr) |=> !tmr_out);

    // R6
    rate_gate_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd2 && !gate_lvl) |-> tmr_out);

    // R5
    rate_single_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 3'd2 && !tmr_out && !mode_wr) |=> tmr_out);

    // R8
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_mode == 3'd4 || cur_mode == 3'd5) && $fell(tmr_out) && !mode_wr) |=> tmr_out);
endmodule

bind interval_timer_channel interval_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wr   (host_mode_wr),
    .load_pulse(host_load),
    .gate_lvl  (sync_lvl),
    .cur_mode  (core_mode),
    .tmr_out   (tmr_out)
);

// File: tb/interval_timer_channel_bench.sv
module interval_timer_channel_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic       gate_in = 1'b0;
    logic [7:0] rd_data;
    logic       tmr_out;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string phase = "R1";

    always #10 clk = ~clk;

    interval_timer_channel u_interval_timer_channel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .gate_in(gate_in), .tmr_out(tmr_out)
    );

    // behavioural reference: state 0 idle, 1 armed, 2 run, 3 strobe, 4 expired
    int m_mode, m_st, m_cnt, m_init, m_per, m_lo, m_wp, m_rp, m_rd;
    bit g_q[$];
    bit g_prev;

    function automatic int map_mode(input int d);
        int v = d & 7;
        return (v >= 6) ? v - 4 : v;
    endfunction

    function automatic bit ref_out();
        bit lvl = g_q[$];
        case (m_st)
            0: return m_mode != 0;
            3: return 0;
            2: begin
                if (m_mode <= 1) return 0;
                if (m_mode == 2) return !(m_cnt == 1 && lvl);
                if (m_mode == 3) return !lvl || (m_cnt > m_per / 2);
                return 1;
            end
            default: return 1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_st = 0; m_cnt = 0; m_init = 0; m_per = 0;
            m_lo = 0; m_wp = 0; m_rp = 0; m_rd = 0; g_prev = 0;
            g_q = '{0, 0};
        end else begin
            automatic bit lvl = g_q[$];
            automatic bit rise = lvl && !g_prev;
            automatic bit mw = wr_en && !wr_addr;
            automatic bit cw = wr_en && wr_addr;
            automatic bit ld = cw && (m_wp == 1);
            automatic int raw = (int'(wr_data) << 8) | m_lo;
            automatic int ldv = (raw == 0) ? 65536 : raw;
            automatic int nst = m_st, ncnt = m_cnt, nper = m_per;
            automatic int nxt_init = ld ? ldv : m_init;
            automatic bit reload_start = (m_mode == 0 || m_mode == 4);
            automatic bit trig_mode = (m_mode == 1 || m_mode == 5);
            automatic bit wave = (m_mode == 2 || m_mode == 3);
            if (mw) begin nst = 0; ncnt = 0; nper = 0; end
            else if (ld && reload_start) begin nst = 2; ncnt = ldv; end
            else if (trig_mode && rise && (m_st != 0 || ld)) begin nst = 2; ncnt = nxt_init; end
            else if (trig_mode && ld && m_st == 0) nst = 1;
            else if (wave && ld && m_st == 0) begin nst = 2; ncnt = ldv; nper = ldv; end
            else if (wave && rise && m_st == 2) begin ncnt = nxt_init; nper = nxt_init; end
            else if (m_st == 2) begin
                if (trig_mode || lvl) begin
                    if (m_cnt == 1) begin
                        if (m_mode == 0) nst = 4;
                        else if (m_mode == 1) nst = 1;
                        else if (wave) begin ncnt = nxt_init; nper = nxt_init; end
                        else begin nst = 3; ncnt = 0; end
                    end else ncnt = m_cnt - 1;
                end
            end else if (m_st == 3) nst = (m_mode == 4) ? 4 : 1;
            if (rd_en) m_rd = m_rp ? ((m_cnt >> 8) & 255) : (m_cnt & 255);
            if (mw) m_rp = 0; else if (rd_en) m_rp ^= 1;
            if (mw) m_wp = 0;
            else if (cw) begin
                if (m_wp == 0) m_lo = wr_data;
                m_wp ^= 1;
            end
            if (ld) m_init = ldv;
            if (mw) m_mode = map_mode(wr_data);
            m_st = nst; m_cnt = ncnt; m_per = nper;
            g_prev = lvl;
            g_q.push_front(gate_in);
            void'(g_q.pop_back());
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            automatic bit eo = ref_out();
            total++;
            if (tmr_out !== eo || rd_data !== m_rd[7:0]) begin
                bad++;
                $display("FAIL %s cycle compare: out=%b rd=%h expected out=%b rd=%h",
                         phase, tmr_out, rd_data, eo, m_rd[7:0]);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input int v);
        wr(1'b1, v[7:0]);
        wr(1'b1, v[15:8]);
    endtask

    task automatic count_level(input bit lvl, output int n);
        n = 0;
        while (tmr_out == lvl) begin n++; @(negedge clk); end
    endtask

    task automatic measure(output int hi, output int lo);
        while (tmr_out != 1'b0) @(negedge clk);
        while (tmr_out != 1'b1) @(negedge clk);
        count_level(1'b1, hi);
        count_level(1'b0, lo);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int h, l;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk(tmr_out == 1'b0, "R1 reset out", tmr_out, 0);
        chk(rd_data == 8'h00, "R1 reset rd_data", rd_data, 0);

        // R2 interrupt on terminal count
        phase = "R2";
        gate_in = 1'b1; idle(4);
        wr(1'b0, 8'h00);
        load(5);
        count_level(1'b0, l);
        chk(l == 5, "R2 low length", l, 5);
        idle(5);
        chk(tmr_out == 1'b1, "R2 stays high", tmr_out, 1);
        load(6); idle(2); gate_in = 1'b0; idle(5); gate_in = 1'b1; idle(12);

        // R5 R6 rate generator
        phase = "R5";
        wr(1'b0, 8'h02); idle(3);
        chk(tmr_out == 1'b1, "R5 high before load", tmr_out, 1);
        load(4);
        measure(h, l);
        chk(h == 3 && l == 1, "R5 period 4 high part", h, 3);
        phase = "R6";
        load(7); idle(10);
        measure(h, l);
        chk(h == 6 && l == 1, "R6 new period high part", h, 6);
        gate_in = 1'b0; idle(6);
        chk(tmr_out == 1'b1, "R6 gate low forces high", tmr_out, 1);
        gate_in = 1'b1; idle(15);

        // R1 alias codes and R7 square wave
        phase = "R1";
        wr(1'b0, 8'h06);
        chk(tmr_out == 1'b1, "R1 code 6 idle high", tmr_out, 1);
        load(3); idle(8);
        phase = "R7";
        wr(1'b0, 8'h03);
        load(5);
        measure(h, l);
        chk(h == 3 && l == 2, "R7 odd high half", h, 3);
        chk(l == 2, "R7 odd low half", l, 2);
        load(6); idle(12);
        measure(h, l);
        chk(h == 3 && l == 3, "R7 even halves", h, 3);
        gate_in = 1'b0; idle(5); gate_in = 1'b1; idle(10);
        wr(1'b0, 8'h07);
        load(4);
        measure(h, l);
        chk(h == 2 && l == 2, "R1 code 7 as square", h, 2);

        // R3 R11 R4 one-shot
        phase = "R3";
        gate_in = 1'b0;
        wr(1'b0, 8'h01); idle(4);
        load(4); idle(3);
        gate_in = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(tmr_out == 1'b1, "R11 not yet triggered", tmr_out, 1);
        @(negedge clk);
        chk(tmr_out == 1'b0, "R11 triggered after sync", tmr_out, 0);
        gate_in = 1'b0; idle(8);
        gate_in = 1'b1; idle(4); gate_in = 1'b0; idle(1); gate_in = 1'b1; idle(10);
        phase = "R4";
        gate_in = 1'b0; idle(4);
        gate_in = 1'b1;
        idle(3);
        l = 1;
        load(9);
        l = l + 1;
        begin
            int rest;
            count_level(1'b0, rest);
            l = l + rest;
        end
        chk(l == 4, "R4 running pulse unchanged", l, 4);
        gate_in = 1'b0; idle(4);
        gate_in = 1'b1; idle(3);
        count_level(1'b0, l);
        chk(l == 9, "R4 next trigger uses new count", l, 9);

        // R12 load and trigger on the same edge
        phase = "R12";
        gate_in = 1'b0; idle(4);
        gate_in = 1'b1;
        wr(1'b1, 8'd6);
        idle(1);
        wr(1'b1, 8'd0);
        count_level(1'b0, l);
        chk(l == 6, "R12 coincident trigger uses new count", l, 6);

        // R8 software strobe
        phase = "R8";
        wr(1'b0, 8'h04);
        chk(tmr_out == 1'b1, "R8 high after mode", tmr_out, 1);
        load(5);
        count_level(1'b1, h);
        chk(h == 5, "R8 count before strobe", h, 5);
        count_level(1'b0, l);
        chk(l == 1, "R8 strobe width", l, 1);
        load(6); idle(2); gate_in = 1'b0; idle(5); gate_in = 1'b1; idle(12);
        load(8); idle(3); load(3); idle(8);

        // R10 readback with frozen count
        phase = "R10";
        gate_in = 1'b0; idle(4);
        load(16'h1234); idle(2);
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        chk(rd_data == 8'h34, "R10 low byte", rd_data, 8'h34);
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        chk(rd_data == 8'h12, "R10 high byte", rd_data, 8'h12);
        chk(tmr_out == 1'b1, "R10 output undisturbed", tmr_out, 1);

        // R9 hardware strobe
        phase = "R9";
        wr(1'b0, 8'h05);
        load(3); idle(3);
        gate_in = 1'b1; idle(3);
        count_level(1'b1, h);
        chk(h == 3, "R9 count before strobe", h, 3);
        count_level(1'b0, l);
        chk(l == 1, "R9 strobe width", l, 1);
        gate_in = 1'b0; idle(3); gate_in = 1'b1; idle(2);
        load(7); idle(10);

        // R13 zero means full range
        phase = "R13";
        wr(1'b0, 8'h00);
        load(0);
        count_level(1'b0, l);
        chk(l == 65536, "R13 zero count length", l, 65536);
        idle(3);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule